// File: doc/BRIEF.md
# Dual-ALU Cascadable Processing Unit

This block is a small compute element with three signed operand inputs and two scalar arithmetic units. A control-word register picks the operation of each unit and the way they are wired. A constant register holds a coefficient that can stand in for the second operand. In single mode only the first unit works, on operands A and B. In cascaded mode the second unit then combines the first unit's result with operand C.

A relay setting skips all arithmetic and copies operand A to the output, so the unit can carry data between neighbouring units. Relational operations return the integer 1 or 0. Several units can use that flag as a multiplier and add the results, which builds a select (cond ? x : y). The result and its valid bit are registered. Configuration arrives on a simple write port that selects either the control word or the constant.

Top module: `dual_alu_pu`

## Requirements
- R1: After reset, out_valid and out_data are 0, the control word is all zeros (single mode, ADD on both units, no relay, no constant) and the constant is 0.
- R2: out_valid equals the in_valid of the previous cycle. A result computed from operands presented with in_valid high appears on out_data at the next rising edge.
- R3: While in_valid is low, out_data keeps its value.
- R4: Opcodes 0 ADD (a+b), 1 SUB (a-b) and 2 MUL (a*b) wrap modulo 2^DATA_W. A product keeps its low DATA_W bits.
- R5: Opcodes 3 MAX and 4 MIN return the signed larger or smaller operand.
- R6: Opcodes 5 (a<b), 6 (a>b) and 7 (a==b) return 1 when the relation holds and 0 otherwise. Opcodes 13, 14 and 15 return the complement of 5, 6 and 7. All comparisons are signed.
- R7: Control bit 10 set makes unit 1 use the constant register in place of operand B.
- R8: Control bit 8 set (cascade) gives out = op2(op1(A,B'), C), where op1 is bits 3:0 and op2 is bits 7:4. With bit 8 clear, out = op1(A,B'), and C and op2 have no effect.
- R9: Control bit 9 set (relay) forwards operand A unchanged, whatever the opcodes, cascade and constant settings.
- R10: cfg_we with cfg_sel=0 loads the control word from cfg_wdata[10:0]. With cfg_sel=1 it loads the constant from cfg_wdata. A write takes effect for operands presented from the next cycle on; operands presented in the same cycle as the write use the old setting.
- R11: Opcode 8 passes the first operand. Opcodes 9 to 12 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: control word, 1: constant |
| cfg_wdata | input | DATA_W | Configuration write data |
| in_valid | input | 1 | Operands valid |
| in_a | input | DATA_W | Signed operand A |
| in_b | input | DATA_W | Signed operand B |
| in_c | input | DATA_W | Signed operand C (cascade input) |
| out_valid | output | 1 | Result valid |
| out_data | output | DATA_W | Signed registered result |

## Verification
Every result is due exactly one rising edge after its operands are presented. The bench drives operands on a falling edge and samples out_data and out_valid on the following falling edge, which is after that single register stage and before the next input. A configuration write reaches its register at the edge that ends the write cycle, so it applies to operands presented from the following cycle. The bench checks this by presenting operands in the write cycle itself and expecting the old setting. Idle cycles are sampled one falling edge later, to check that the output holds and that out_valid is low.

// File: rtl/pu_pkg.sv
package pu_pkg;

    localparam int OPC_W  = 4;
    localparam int CTRL_W = 11;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 4'd0,
        OPC_SUB  = 4'd1,
        OPC_MUL  = 4'd2,
        OPC_MAX  = 4'd3,
        OPC_MIN  = 4'd4,
        OPC_CLT  = 4'd5,
        OPC_CGT  = 4'd6,
        OPC_CEQ  = 4'd7,
        OPC_PASS = 4'd8,
        OPC_NLT  = 4'd13,
        OPC_NGT  = 4'd14,
        OPC_NEQ  = 4'd15
    } pu_opc_e;

    // bit order matters: software packs the control word this way
    typedef struct packed {
        logic             use_const;  // bit 10
        logic             relay;      // bit 9
        logic             cascade;    // bit 8
        logic [OPC_W-1:0] op2;        // bits 7:4
        logic [OPC_W-1:0] op1;        // bits 3:0
    } pu_ctrl_t;

endpackage

// File: rtl/pu_scalar_alu.sv
module pu_scalar_alu #(
    parameter int DATA_W = 16
) (
    input  logic [pu_pkg::OPC_W-1:0] op,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [DATA_W-1:0] y
);
    import pu_pkg::*;

    localparam logic signed [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic signed [DATA_W-1:0] ZERO = '0;

    logic lt, gt, eq;

    always_comb begin
        lt = (a < b);
        gt = (a > b);
        eq = (a == b);
        unique case (op)
            OPC_ADD:  y = a + b;
            OPC_SUB:  y = a - b;
            OPC_MUL:  y = a * b;
            OPC_MAX:  y = gt ? a : b;
            OPC_MIN:  y = lt ? a : b;
            OPC_CLT:  y = lt ? ONE : ZERO;
            OPC_CGT:  y = gt ? ONE : ZERO;
            OPC_CEQ:  y = eq ? ONE : ZERO;
            OPC_PASS: y = a;
            OPC_NLT:  y = lt ? ZERO : ONE;
            OPC_NGT:  y = gt ? ZERO : ONE;
            OPC_NEQ:  y = eq ? ZERO : ONE;
            default:  y = ZERO;
        endcase
    end

    always_comb begin
        if (op inside {OPC_CLT, OPC_CGT, OPC_CEQ, OPC_NLT, OPC_NGT, OPC_NEQ}) begin
            AST_CMP_BOOL: assert (y == ZERO || y == ONE)
                else $error("compare result not boolean"); // R6
        end
    end

endmodule

// File: rtl/pu_cfg_regs.sv
module pu_cfg_regs #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     sel,
    input  logic [DATA_W-1:0]        wdata,
    output pu_pkg::pu_ctrl_t         ctrl,
    output logic signed [DATA_W-1:0] konst
);
    import pu_pkg::*;

    typedef struct packed {
        pu_ctrl_t           ctrl;
        logic [DATA_W-1:0]  konst;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (sel) st_d.konst = wdata;
            else     st_d.ctrl  = pu_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl  = st_q.ctrl;
    assign konst = st_q.konst;

    AST_CONST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel) |=> (konst == $past(wdata))) else $error("constant load"); // R10
    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && !sel) |=> $stable(ctrl)) else $error("control changed without write"); // R10

endmodule

// File: rtl/dual_alu_pu.sv
module dual_alu_pu #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [DATA_W-1:0]        cfg_wdata,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_a,
    input  logic signed [DATA_W-1:0] in_b,
    input  logic signed [DATA_W-1:0] in_c,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    import pu_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_state_t;

    pu_ctrl_t                 ctrl;
    logic signed [DATA_W-1:0] konst;
    logic signed [DATA_W-1:0] opnd_b;
    logic signed [DATA_W-1:0] res1;
    logic signed [DATA_W-1:0] res2;
    out_state_t               st_d, st_q;

    pu_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .konst (konst)
    );

    assign opnd_b = ctrl.use_const ? konst : in_b;

    pu_scalar_alu #(.DATA_W(DATA_W)) u_alu1 (
        .op (ctrl.op1),
        .a  (in_a),
        .b  (opnd_b),
        .y  (res1)
    );

    pu_scalar_alu #(.DATA_W(DATA_W)) u_alu2 (
        .op (ctrl.op2),
        .a  (res1),
        .b  (in_c),
        .y  (res2)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (ctrl.relay)        st_d.data = in_a;
            else if (ctrl.cascade) st_d.data = res2;
            else                   st_d.data = res1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid lost"); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("spurious valid"); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)) else $error("output moved while idle"); // R3
    AST_RELAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl.relay) |=> (out_data == $past(in_a))) else $error("relay altered data"); // R9

endmodule

// File: tb/dual_alu_pu_bench.sv
module dual_alu_pu_bench;

    localparam int W = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_we = 1'b0;
    logic                cfg_sel = 1'b0;
    logic [W-1:0]        cfg_wdata = '0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_a = '0, in_b = '0, in_c = '0;
    logic                out_valid;
    logic signed [W-1:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    logic [10:0]         m_ctrl = '0;
    logic signed [W-1:0] m_const = '0;

    always #5 clk = ~clk;

    dual_alu_pu #(.DATA_W(W)) u_dual_alu_pu (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic signed [W-1:0] f_op(input logic [3:0] op,
                                                 input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
        int x = a;
        int y = b;
        int r;
        case (op)
            4'd0:  r = x + y;
            4'd1:  r = x - y;
            4'd2:  r = x * y;
            4'd3:  r = (x > y) ? x : y;
            4'd4:  r = (x < y) ? x : y;
            4'd5:  r = int'(x < y);
            4'd6:  r = int'(x > y);
            4'd7:  r = int'(x == y);
            4'd8:  r = x;
            4'd13: r = int'(x >= y);
            4'd14: r = int'(x <= y);
            4'd15: r = int'(x != y);
            default: r = 0;
        endcase
        return r[W-1:0];
    endfunction

    function automatic logic signed [W-1:0] f_model(input logic signed [W-1:0] a,
                                                    input logic signed [W-1:0] b,
                                                    input logic signed [W-1:0] c);
        logic signed [W-1:0] bb = m_ctrl[10] ? m_const : b;
        logic signed [W-1:0] r1;
        if (m_ctrl[9]) return a;
        r1 = f_op(m_ctrl[3:0], a, bb);
        return m_ctrl[8] ? f_op(m_ctrl[7:4], r1, c) : r1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_const = d;
        else     m_ctrl  = d[10:0];
    endtask

    task automatic run(input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                       input logic signed [W-1:0] c, input string req);
        logic signed [W-1:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_c = c;
        e = f_model(a, b, c);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, {req, " valid"}, int'(out_valid), 1);
        chk(out_data === e, req, int'(out_data), int'(e));
    endtask

    task automatic idle_check(input string req);
        logic signed [W-1:0] prev = out_data;
        @(negedge clk);
        in_a = 16'sd999; in_b = -16'sd5; in_c = 16'sd7;
        @(negedge clk);
        chk(out_valid === 1'b0, {req, " idle valid"}, int'(out_valid), 0);
        chk(out_data === prev, {req, " hold"}, int'(out_data), int'(prev));
    endtask

    function automatic logic [W-1:0] mk(input int op1, input int op2, input bit casc,
                                        input bit rel, input bit kon);
        logic [W-1:0] w = '0;
        w[3:0] = op1[3:0]; w[7:4] = op2[3:0];
        w[8] = casc; w[9] = rel; w[10] = kon;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_data === '0, "R1 data", int'(out_data), 0);
        run(16'sd3, 16'sd4, 16'sd100, "R1 default add"); // expects 7, proves zero control word
        idle_check("R3");
        // R4 arithmetic
        cfg_write(1'b0, mk(1, 0, 0, 0, 0));
        run(-16'sd32768, 16'sd1, 0, "R4 sub wrap");
        cfg_write(1'b0, mk(2, 0, 0, 0, 0));
        run(16'sd300, 16'sd300, 0, "R4 mul low bits");
        // R5
        cfg_write(1'b0, mk(3, 0, 0, 0, 0));
        run(-16'sd9, 16'sd2, 0, "R5 max");
        cfg_write(1'b0, mk(4, 0, 0, 0, 0));
        run(-16'sd9, 16'sd2, 0, "R5 min");
        // R6 compares and complements
        for (int op = 5; op <= 15; op++) begin
            if (op > 7 && op < 13) continue;
            cfg_write(1'b0, mk(op, 0, 0, 0, 0));
            run(-16'sd1, 16'sd1, 0, "R6 cmp lt");
            run(16'sd4, 16'sd4, 0, "R6 cmp eq");
        end
        // R11
        cfg_write(1'b0, mk(8, 0, 0, 0, 0));
        run(16'sd77, 16'sd1, 0, "R11 pass");
        cfg_write(1'b0, mk(10, 0, 0, 0, 0));
        run(16'sd77, 16'sd1, 0, "R11 reserved");
        // R7 constant in place of B
        cfg_write(1'b1, 16'sd10);
        cfg_write(1'b0, mk(2, 0, 0, 0, 1));
        run(16'sd6, 16'sd3, 0, "R7 const");
        // R8 cascade select pieces: (a<b)*c
        cfg_write(1'b0, mk(5, 2, 1, 0, 0));
        run(16'sd1, 16'sd2, 16'sd55, "R8 flag times c true");
        run(16'sd3, 16'sd2, 16'sd55, "R8 flag times c false");
        cfg_write(1'b0, mk(0, 2, 0, 0, 0));
        run(16'sd1, 16'sd2, 16'sd55, "R8 single ignores c");
        run(16'sd1, 16'sd2, -16'sd9, "R8 single ignores c again");
        // R9 relay
        cfg_write(1'b0, mk(2, 1, 1, 1, 1));
        run(-16'sd1234, 16'sd5, 16'sd6, "R9 relay");
        // R10 write and operands in the same cycle: old config applies
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = mk(1, 0, 0, 0, 0);
        in_valid = 1'b1; in_a = 16'sd20; in_b = 16'sd3; in_c = 0;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        chk(out_data === 16'sd20, "R10 old config", int'(out_data), 20);
        m_ctrl = mk(1, 0, 0, 0, 0);
        run(16'sd20, 16'sd3, 0, "R10 new config");
        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 8 == 0) cfg_write(1'b0, W'($urandom) & 16'h07ff);
            if (i % 16 == 3) cfg_write(1'b1, W'($urandom));
            run(W'($urandom), W'($urandom), W'($urandom), "R8 random");
            if (i % 25 == 0) idle_check("R3 random");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule